// File: doc/BRIEF.md
# Two-wire serial target with pointer-addressed RAM

This block is a target (slave) on a two-wire serial bus with open-drain lines. It lets a bus controller reach a small byte-wide RAM through an internal location pointer. The clock and data lines are first brought into the system clock domain by synchronizer flops. The block then looks for start and stop conditions and shifts in the address byte. It takes part in a transfer only when the 7 address bits equal its own address. When they do not match, it stays silent until the bus is freed.

In a write transfer, the first byte after the address sets the pointer, and every later byte is stored at the pointer. In a read transfer, the block returns bytes starting at the pointer. Each byte stored or returned moves the pointer on by one. The pointer survives repeated starts and stops, so a controller can set it in a write and then read from that place after a repeated start. The data line is never driven high: the block only pulls it low through an output enable.

Top module: `twr_ptr_ram`

## Requirements
- R1: The address byte is shifted in MSB first. Bits 7..1 are the target address and bit 0 is the direction (0 = write, 1 = read). When the address matches DEV_ADDR, the block pulls SDA low for the whole ninth SCL clock.
- R2: After an address that does not match, the block leaves SDA released for the rest of the transfer, including later bytes, until the next STOP or START.
- R3: In a write transfer, the first byte after the address loads the pointer (its low log2(DEPTH) bits). Each later byte is stored at the pointer. Every byte received in a matched write is acknowledged with SDA low on the ninth clock.
- R4: In a read transfer, the block returns the RAM byte at the pointer, MSB first. Its SDA level changes only after a falling SCL edge, so it is stable while SCL is high.
- R5: The pointer advances by one after each byte stored or returned, and it wraps from DEPTH-1 to 0.
- R6: A repeated START at any point, even in the middle of a byte, returns the block to address reception and keeps the pointer. A partial byte is discarded.
- R7: A STOP at any point, even in the middle of a byte, releases SDA and makes the block wait for a new START. A partial byte is not stored, and the pointer keeps the value it had.
- R8: During a read, a controller acknowledge (SDA low on the ninth clock) asks for the next byte. A missing acknowledge ends data output, and SDA stays released until the next START or STOP.
- R9: After reset, SDA is released and the pointer is 0. The RAM contents are not cleared by reset.
- R10: SDA is driven only through `sda_oe`, where 1 means pull low. Both bus inputs pass through SYNC_STAGES flops before any decision is made on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with DEPTH = 128 and DEV_ADDR = 0x2A, the default pointer space. With these values every 7-bit address can be offered in turn, and every RAM location can be filled in one burst and then read back in one burst. The pointer wrap from 127 to 0 falls inside both bursts. Shorter transfers then cover these cases, each against a byte model kept in the bench:
- a write followed by a read across a repeated start;
- a stop or a repeated start in the middle of a byte;
- a read that the controller does not acknowledge;
- a second reset.

// File: rtl/twr_pkg.sv
package twr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WRX,
    ST_WACK,
    ST_RTX,
    ST_RACK,
    ST_SKIP
  } state_e;
endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s, scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      logic scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
      assign scl_s = scl_q;
      assign sda_s = sda_q;
    end else begin : g_many
      logic [STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_q[STAGES-1];
      assign sda_s = sda_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twr_ram.sv
module twr_ram #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twr_ctrl.sv
module twr_ctrl
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [7:0]    wdata,
  output state_e        state
);
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       is_read;
  logic       ptr_pend;
  logic       m_ack;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      is_read  <= 1'b0;
      ptr_pend <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      ptr      <= '0;
      we       <= 1'b0;
      waddr    <= '0;
      wdata    <= '0;
    end else begin
      we <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WRX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  state    <= ST_AACK;
                  sda_oe   <= 1'b1;
                  is_read  <= shreg[0];
                  ptr_pend <= ~shreg[0];
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state  <= ST_WACK;
                sda_oe <= 1'b1;
                if (ptr_pend) begin
                  ptr      <= shreg[AW-1:0];
                  ptr_pend <= 1'b0;
                end else begin
                  we    <= 1'b1;
                  waddr <= ptr;
                  wdata <= shreg;
                  ptr   <= bump(ptr);
                end
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (state == ST_AACK && !is_read) begin
                state  <= ST_WRX;
                sda_oe <= 1'b0;
              end else if (state == ST_AACK || m_ack) begin
                state  <= ST_RTX;
                shreg  <= rdata;
                sda_oe <= ~rdata[7];
                ptr    <= bump(ptr);
              end else begin
                state  <= ST_SKIP;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              state  <= ST_WRX;
              sda_oe <= 1'b0;
              cnt    <= '0;
            end
          end
          ST_RTX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                state  <= ST_RACK;
                sda_oe <= 1'b0;
                cnt    <= '0;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twr_ptr_ram.sv
module twr_ptr_ram
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int DEPTH = 128,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]    rdata, wdata;
  logic [AW-1:0] ptr, waddr;
  logic          we;
  state_e        state;

  twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twr_ctrl #(.DEV_ADDR(DEV_ADDR), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rdata(rdata), .sda_oe(sda_oe), .ptr(ptr), .we(we),
    .waddr(waddr), .wdata(wdata), .state(state)
  );

  twr_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ptr), .rdata(rdata)
  );
endmodule

// File: rtl/twr_ptr_ram_chk.sv
module twr_ptr_ram_chk
  import twr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          scl_fall,
  input logic          start_det,
  input logic          stop_det,
  input logic          we,
  input logic [AW-1:0] ptr,
  input state_e        state
);
  // R4 and R10: the output enable moves only after a falling SCL or a bus condition
  p_oe_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

  // R2 and R8: a skipped transfer never drives the line
  p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);

  // R7: a stop releases the line and idles
  p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state == ST_IDLE) && !sda_oe);

  // R6: a start always returns to address reception
  p_start_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && !sda_oe);

  // R5: a store advances the pointer by one with wrap
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ptr == (($past(ptr) == AW'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1));

  // R6 and R7: bus conditions never move the pointer
  p_ptr_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_det || stop_det |=> $stable(ptr));
endmodule

bind twr_ptr_ram twr_ptr_ram_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .we(we), .ptr(ptr),
  .state(state)
);

// File: tb/twr_ptr_ram_bench.sv
module twr_ptr_ram_bench;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int DEPTH = 128;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  int mptr = 0;

  always #5 clk = ~clk;

  twr_ptr_ram #(.DEV_ADDR(DEV), .DEPTH(DEPTH)) u_twr_ptr_ram (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(HALF);
    scl_m = 1'b1; wt(HALF);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wt(HALF);
    scl_m = 1'b1; wt(HALF / 2);
    ack = ~sda_line;
    wt(HALF / 2);
    scl_m = 1'b0; wt(2);
  endtask

  // reads one byte, checks line stability while SCL high (R4), then acks or not
  task automatic recv_byte(input logic give_ack, output logic [7:0] d, output int unstable);
    logic a, b;
    unstable = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wt(HALF);
      scl_m = 1'b1; wt(1);
      a = sda_line;
      wt(HALF - 2);
      b = sda_line;
      wt(1);
      d[i] = b;
      if (a != b) unstable++;
      scl_m = 1'b0; wt(2);
    end
    send_bit(~give_ack);
  endtask

  task automatic addr(input logic [6:0] a, input logic rd, output logic ack);
    send_byte({a, rd}, ack);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    int uns, nacks, bad;
    wt(4);
    chk("R9 reset releases SDA", int'(sda_oe), 0);
    rst_n = 1'b1;
    wt(4);
    chk("R9 idle after reset", int'(sda_oe), 0);

    // R1 / R2: sweep all 7-bit addresses in write mode
    bad = 0;
    for (int a = 0; a < 128; a++) begin
      bus_start();
      addr(7'(a), 1'b0, ack);
      if (ack != (7'(a) == DEV)) bad++;
      bus_stop();
    end
    chk("R1 ack only on own address (sweep)", bad, 0);

    // R2: non-matching read address, later bytes unacked, line released
    bus_start();
    addr(DEV ^ 7'h01, 1'b1, ack);
    chk("R2 foreign read address not acked", int'(ack), 0);
    send_byte(8'h00, ack);
    chk("R2 later byte ignored", int'(ack), 0);
    chk("R2 line released", int'(sda_oe), 0);
    bus_stop();

    // R3: full write burst from pointer 0
    bus_start();
    addr(DEV, 1'b0, ack);
    chk("R1 own write address acked", int'(ack), 1);
    send_byte(8'h00, ack);
    chk("R3 pointer byte acked", int'(ack), 1);
    mptr = 0;
    nacks = 0;
    for (int i = 0; i < DEPTH; i++) begin
      send_byte(pat(i), ack);
      model[mptr] = pat(i);
      mptr = (mptr + 1) % DEPTH;
      if (!ack) nacks++;
    end
    chk("R3 every data byte acked", nacks, 0);
    bus_stop();

    // R4 / R5: read whole memory from retained pointer (wrapped to 0)
    bus_start();
    addr(DEV, 1'b1, ack);
    chk("R1 own read address acked", int'(ack), 1);
    bad = 0;
    uns = 0;
    for (int i = 0; i < DEPTH; i++) begin
      int u;
      recv_byte(i != DEPTH - 1, d, u);
      uns += u;
      if (d != model[mptr]) bad++;
      mptr = (mptr + 1) % DEPTH;
    end
    chk("R4 read burst matches model", bad, 0);
    chk("R4 SDA stable while SCL high", uns, 0);
    chk("R8 SDA released after NACK", int'(sda_oe), 0);
    bus_stop();

    // R5 / R6: write across wrap, repeated start, then read
    bus_start();
    addr(DEV, 1'b0, ack);
    send_byte(8'd126, ack);
    mptr = 126;
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hA0 + 8'(i), ack);
      model[mptr] = 8'hA0 + 8'(i);
      mptr = (mptr + 1) % DEPTH;
    end
    bus_start();
    addr(DEV, 1'b0, ack);
    send_byte(8'd125, ack);
    mptr = 125;
    bus_start();
    addr(DEV, 1'b1, ack);
    chk("R6 read after repeated start acked", int'(ack), 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d, uns);
      chk("R5 wrap write and read-back", int'(d), int'(model[mptr]));
      mptr = (mptr + 1) % DEPTH;
    end
    // R8: after NACK, extra clocks see a released line
    recv_byte(1'b0, d, uns);
    chk("R8 no output after master NACK", int'(d), 255);
    bus_stop();

    // R7: stop inside a data byte
    bus_start();
    addr(DEV, 1'b0, ack);
    send_byte(8'd10, ack);
    mptr = 10;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R7 line released after stop", int'(sda_oe), 0);
    bus_start();
    addr(DEV, 1'b1, ack);
    chk("R7 new transfer after stop", int'(ack), 1);
    recv_byte(1'b0, d, uns);
    chk("R7 partial byte not stored", int'(d), int'(model[10]));
    bus_stop();

    // R6: repeated start inside a data byte
    bus_start();
    addr(DEV, 1'b0, ack);
    send_byte(8'd20, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start();
    addr(DEV, 1'b1, ack);
    recv_byte(1'b0, d, uns);
    chk("R6 pointer kept over mid-byte restart", int'(d), int'(model[20]));
    bus_stop();

    // R9: second reset, pointer back to 0, RAM kept
    rst_n = 1'b0; wt(3); rst_n = 1'b1; wt(3);
    chk("R9 SDA released in reset", int'(sda_oe), 0);
    bus_start();
    addr(DEV, 1'b1, ack);
    recv_byte(1'b0, d, uns);
    chk("R9 pointer zero after reset", int'(d), int'(model[0]));
    chk("R10 line released between transfers", int'(sda_oe), 0);
    bus_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule